// File: doc/BRIEF.md
# Memory-Mode Flash Card Host Controller

This block sits between on-chip logic and a removable flash storage card that is used in its memory-mapped mode. Upstream it accepts one access at a time: a read or write, an 11-bit card address, a choice between the common and attribute spaces, a transfer size and the write data. It answers with a one-cycle done pulse and, for reads, the returned data. Downstream it drives the card address, the two active-low byte enables, the active-low space-select line, the read and write strobes, the active-high card reset, and a 16-bit bidirectional data bus. It also watches the card's READY line, which is low while the card is busy.

After the chip reset is released, the controller holds the card in reset for a fixed number of cycles. It then waits for READY before it calls itself initialised. Every access runs through three timed phases: address setup, strobe pulse and hold. The length of each phase in clock cycles is set by a parameter. READY passes through a short synchroniser, and no access starts unless the synchronised READY is high.

Top module: `cf_mem_host`

## Requirements
- R1: While `rst_ni` is low and for RST_CYC clock cycles after it is released, `card_reset_o` is 1, both enables are 1, both strobes are 1 and `req_ready_o` is 0.
- R2: `init_done_o` goes to 1 only once the card reset has ended and the synchronised READY is 1. No request is accepted before that.
- R3: Size code 2'b01 (word; 2'b11 behaves the same) drives both enables low and forces address bit 0 to 0. It moves D15..D0, and the read result equals the whole bus.
- R4: Size code 2'b00 (byte) drives only `card_ce1_no` low and passes address bit 0 through unchanged. It moves data on D7..D0 only. The read result is {8'h00, D7..D0}, and a write places `req_wdata_i[7:0]` on D7..D0.
- R5: Size code 2'b10 (odd byte) drives only `card_ce2_no` low. It moves data on D15..D8 only. The read result is {8'h00, D15..D8}, and a write places `req_wdata_i[7:0]` on D15..D8.
- R6: `card_reg_no` is 1 for a common-space access (`req_attr_i`=0) and 0 for an attribute-space access (`req_attr_i`=1). The address and `card_reg_no` stay stable for the whole access.
- R7: A read pulses only `card_oe_no`, and `card_we_no` stays 1. The read data is captured on the clock edge that ends the last cycle of the strobe.
- R8: A write pulses only `card_we_no`, and `card_oe_no` stays 1. The controller drives the data bus only during a write access and leaves it high-impedance at all other times.
- R9: The enables are low for SETUP_CYC cycles before the strobe falls. The strobe is low for PULSE_CYC cycles. The enables stay low for HOLD_CYC cycles after the strobe rises.
- R10: Each accepted request (`req_valid_i` and `req_ready_o` both high at a clock edge) produces exactly one single-cycle `rsp_done_o` pulse. This pulse comes in the cycle in which the enables return high. `req_ready_o` is 0 while an access is in progress.
- R11: While READY is low, a pending request is held off and no enable is asserted. After READY rises, the request is taken and carried out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 11 | Card address |
| req_attr_i | input | 1 | 1 = attribute space, 0 = common space |
| req_size_i | input | 2 | 00 byte, 01 word, 10 odd byte, 11 word |
| req_wdata_i | input | 16 | Write data |
| req_ready_o | output | 1 | Controller can accept a request |
| rsp_done_o | output | 1 | One-cycle completion pulse |
| rsp_rdata_o | output | 16 | Read result, valid with done |
| init_done_o | output | 1 | Card reset finished and card ready |
| card_addr_o | output | 11 | Card address lines |
| card_ce1_no | output | 1 | Lower byte enable, active low |
| card_ce2_no | output | 1 | Upper byte enable, active low |
| card_reg_no | output | 1 | Space select, low = attribute |
| card_oe_no | output | 1 | Read strobe, active low |
| card_we_no | output | 1 | Write strobe, active low |
| card_reset_o | output | 1 | Card reset, active high |
| card_data_io | inout | 16 | Card data bus |
| card_ready_i | input | 1 | Card READY, low = busy |

## Verification
Two events can land in the same cycle.

The first pair is the release of the busy line and a request that has been waiting for it. The bench holds a byte read on the request port while READY is low and confirms that no enable moves. It then raises READY and checks that the access that follows is complete and correct.

The second pair is the done pulse of one access and the acceptance of the next. Back-to-back requests of mixed sizes and spaces are issued so that each new request meets `req_ready_o` in the very cycle that `rsp_done_o` is high. The bench checks that every access still gets its own phase lengths, lane pattern and single done pulse.

// File: rtl/cf_mem_pkg.sv
package cf_mem_pkg;
  localparam int CF_AW = 11;
  localparam int CF_DW = 16;
  localparam int CF_LANES = CF_DW / 8;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_WORD = 2'b01,
    SZ_ODD  = 2'b10,
    SZ_WIDE = 2'b11
  } cf_size_e;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_SETUP,
    PH_PULSE,
    PH_HOLD
  } cf_phase_e;

  typedef struct packed {
    logic             write;
    logic             attr;
    cf_size_e         size;
    logic [CF_AW-1:0] addr;
    logic [CF_DW-1:0] wdata;
  } cf_req_t;
endpackage

// File: rtl/cf_reset_seq.sv
module cf_reset_seq #(
  parameter int RST_CYC = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rdy_i,
  output logic card_reset_o,
  output logic init_done_o
);
  localparam int CW = $clog2(RST_CYC + 1);

  logic [CW-1:0] cnt_q;
  logic          init_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= CW'(RST_CYC);
      init_q <= 1'b0;
    end else begin
      if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
      else if (rdy_i)  init_q <= 1'b1;
    end
  end

  assign card_reset_o = (cnt_q != '0);
  assign init_done_o  = init_q;
endmodule

// File: rtl/cf_lane_map.sv
module cf_lane_map
  import cf_mem_pkg::*;
(
  input  cf_size_e             size_i,
  input  logic                 addr_lsb_i,
  input  logic [CF_DW-1:0]     wdata_i,
  input  logic [CF_DW-1:0]     bus_i,
  output logic                 ce1_n_o,
  output logic                 ce2_n_o,
  output logic                 a0_o,
  output logic [CF_LANES-1:0]  lane_en_o,
  output logic [CF_DW-1:0]     bus_o,
  output logic [CF_DW-1:0]     rdata_o
);
  always_comb begin
    unique case (size_i)
      SZ_BYTE: begin
        ce1_n_o   = 1'b0;
        ce2_n_o   = 1'b1;
        a0_o      = addr_lsb_i;
        lane_en_o = 2'b01;
        bus_o     = {8'h00, wdata_i[7:0]};
        rdata_o   = {8'h00, bus_i[7:0]};
      end
      SZ_ODD: begin
        ce1_n_o   = 1'b1;
        ce2_n_o   = 1'b0;
        a0_o      = addr_lsb_i;
        lane_en_o = 2'b10;
        bus_o     = {wdata_i[7:0], 8'h00};
        rdata_o   = {8'h00, bus_i[15:8]};
      end
      default: begin
        ce1_n_o   = 1'b0;
        ce2_n_o   = 1'b0;
        a0_o      = 1'b0;
        lane_en_o = 2'b11;
        bus_o     = wdata_i;
        rdata_o   = bus_i;
      end
    endcase
  end
endmodule

// File: rtl/cf_access_seq.sv
module cf_access_seq
  import cf_mem_pkg::*;
#(
  parameter int SETUP_CYC = 2,
  parameter int PULSE_CYC = 3,
  parameter int HOLD_CYC  = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic write_i,
  output logic active_o,
  output logic oe_n_o,
  output logic we_n_o,
  output logic drive_o,
  output logic capture_o,
  output logic done_o
);
  localparam int MAXC = (SETUP_CYC > PULSE_CYC) ?
                        ((SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC) :
                        ((PULSE_CYC > HOLD_CYC) ? PULSE_CYC : HOLD_CYC);
  localparam int CW = (MAXC > 1) ? $clog2(MAXC) : 1;

  cf_phase_e     ph_q;
  logic [CW-1:0] cnt_q;
  logic          done_q;
  logic          last;

  assign last = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= PH_IDLE;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (ph_q)
        PH_IDLE: if (start_i) begin
          ph_q  <= PH_SETUP;
          cnt_q <= CW'(SETUP_CYC - 1);
        end
        PH_SETUP: if (last) begin
          ph_q  <= PH_PULSE;
          cnt_q <= CW'(PULSE_CYC - 1);
        end else cnt_q <= cnt_q - 1'b1;
        PH_PULSE: if (last) begin
          ph_q  <= PH_HOLD;
          cnt_q <= CW'(HOLD_CYC - 1);
        end else cnt_q <= cnt_q - 1'b1;
        PH_HOLD: if (last) begin
          ph_q   <= PH_IDLE;
          done_q <= 1'b1;
        end else cnt_q <= cnt_q - 1'b1;
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  assign active_o  = (ph_q != PH_IDLE);
  assign oe_n_o    = !((ph_q == PH_PULSE) && !write_i);
  assign we_n_o    = !((ph_q == PH_PULSE) && write_i);
  assign drive_o   = active_o && write_i;
  assign capture_o = (ph_q == PH_PULSE) && last && !write_i;
  assign done_o    = done_q;
endmodule

// File: rtl/cf_mem_host.sv
module cf_mem_host
  import cf_mem_pkg::*;
#(
  parameter int SETUP_CYC   = 2,
  parameter int PULSE_CYC   = 3,
  parameter int HOLD_CYC    = 1,
  parameter int RST_CYC     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic             req_write_i,
  input  logic [CF_AW-1:0] req_addr_i,
  input  logic             req_attr_i,
  input  logic [1:0]       req_size_i,
  input  logic [CF_DW-1:0] req_wdata_i,
  output logic             req_ready_o,
  output logic             rsp_done_o,
  output logic [CF_DW-1:0] rsp_rdata_o,
  output logic             init_done_o,
  output logic [CF_AW-1:0] card_addr_o,
  output logic             card_ce1_no,
  output logic             card_ce2_no,
  output logic             card_reg_no,
  output logic             card_oe_no,
  output logic             card_we_no,
  output logic             card_reset_o,
  inout  wire  [CF_DW-1:0] card_data_io,
  input  logic             card_ready_i
);
  logic [SYNC_STAGES-1:0] rdy_pipe_q;
  logic                   rdy_sync;
  cf_req_t                req_q;
  logic [CF_DW-1:0]       rdata_q;
  logic                   accept;
  logic                   active, drive, capture;
  logic                   oe_n, we_n;
  logic                   ce1_n, ce2_n, a0;
  logic [CF_LANES-1:0]    lane_en;
  logic [CF_DW-1:0]       bus_out, lane_rdata;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdy_pipe_q <= '0;
    else         rdy_pipe_q <= SYNC_STAGES'({rdy_pipe_q, card_ready_i});
  end
  assign rdy_sync = rdy_pipe_q[SYNC_STAGES-1];

  cf_reset_seq #(.RST_CYC(RST_CYC)) u_rst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rdy_i       (rdy_sync),
    .card_reset_o(card_reset_o),
    .init_done_o (init_done_o)
  );

  assign req_ready_o = !active && init_done_o && rdy_sync;
  assign accept      = req_valid_i && req_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q <= '0;
    end else if (accept) begin
      req_q.write <= req_write_i;
      req_q.attr  <= req_attr_i;
      req_q.size  <= cf_size_e'(req_size_i);
      req_q.addr  <= req_addr_i;
      req_q.wdata <= req_wdata_i;
    end
  end

  cf_access_seq #(
    .SETUP_CYC(SETUP_CYC),
    .PULSE_CYC(PULSE_CYC),
    .HOLD_CYC (HOLD_CYC)
  ) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (accept),
    .write_i  (req_q.write),
    .active_o (active),
    .oe_n_o   (oe_n),
    .we_n_o   (we_n),
    .drive_o  (drive),
    .capture_o(capture),
    .done_o   (rsp_done_o)
  );

  cf_lane_map u_lane (
    .size_i    (req_q.size),
    .addr_lsb_i(req_q.addr[0]),
    .wdata_i   (req_q.wdata),
    .bus_i     (card_data_io),
    .ce1_n_o   (ce1_n),
    .ce2_n_o   (ce2_n),
    .a0_o      (a0),
    .lane_en_o (lane_en),
    .bus_o     (bus_out),
    .rdata_o   (lane_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_q <= '0;
    else if (capture) rdata_q <= lane_rdata;
  end
  assign rsp_rdata_o = rdata_q;

  assign card_addr_o = active ? {req_q.addr[CF_AW-1:1], a0} : '0;
  assign card_ce1_no = active ? ce1_n : 1'b1;
  assign card_ce2_no = active ? ce2_n : 1'b1;
  assign card_reg_no = active ? !req_q.attr : 1'b1;
  assign card_oe_no  = oe_n;
  assign card_we_no  = we_n;

  for (genvar l = 0; l < CF_LANES; l++) begin : g_lane
    assign card_data_io[8*l +: 8] = (drive && lane_en[l]) ? bus_out[8*l +: 8] : 8'hzz;
  end
endmodule

// File: rtl/cf_mem_host_chk.sv
module cf_mem_host_chk
  import cf_mem_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_ready_o,
  input logic             rsp_done_o,
  input logic             init_done_o,
  input logic [CF_AW-1:0] card_addr_o,
  input logic             card_ce1_no,
  input logic             card_ce2_no,
  input logic             card_reg_no,
  input logic             card_oe_no,
  input logic             card_we_no,
  input logic             card_reset_o,
  input logic             rdy_sync_i
);
  logic idle_en;
  assign idle_en = card_ce1_no && card_ce2_no;

  AST_RESET_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    card_reset_o |-> idle_en);  // R1

  AST_START_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!idle_en && $past(idle_en)) |-> $past(rdy_sync_i && init_done_o));  // R11

  AST_WORD_EVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!card_ce1_no && !card_ce2_no) |-> !card_addr_o[0]);  // R3

  AST_ONE_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!card_oe_no && !card_we_no));  // R7

  AST_STROBE_ENCLOSED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!card_oe_no || !card_we_no) |-> !idle_en);  // R9

  AST_ADDR_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!idle_en && !$past(idle_en)) |-> ($stable(card_addr_o) && $stable(card_reg_no)));  // R6

  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_done_o |=> !rsp_done_o);  // R10

  AST_BUSY_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !idle_en |-> !req_ready_o);  // R10
endmodule

bind cf_mem_host cf_mem_host_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_ready_o (req_ready_o),
  .rsp_done_o  (rsp_done_o),
  .init_done_o (init_done_o),
  .card_addr_o (card_addr_o),
  .card_ce1_no (card_ce1_no),
  .card_ce2_no (card_ce2_no),
  .card_reg_no (card_reg_no),
  .card_oe_no  (card_oe_no),
  .card_we_no  (card_we_no),
  .card_reset_o(card_reset_o),
  .rdy_sync_i  (rdy_sync)
);

// File: tb/cf_mem_host_tb_top.sv
module cf_mem_host_tb_top;
  localparam int SETUP = 2;
  localparam int PULSE = 3;
  localparam int HOLD  = 1;
  localparam int RSTC  = 8;

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        req_valid, req_write, req_attr;
  logic [10:0] req_addr;
  logic [1:0]  req_size;
  logic [15:0] req_wdata;
  logic        req_ready, rsp_done, init_done;
  logic [15:0] rsp_rdata;
  logic [10:0] card_addr;
  logic        ce1_n, ce2_n, reg_n, oe_n, we_n, card_rst;
  wire  [15:0] card_data;
  logic        card_rdy;

  always #10 clk_i = ~clk_i;

  function automatic logic [15:0] pat(input logic [10:0] a);
    return {~a[7:0], a[7:0] ^ {a[10:8], 5'h15}};
  endfunction

  assign card_data = !oe_n ? pat(card_addr) : 16'hzzzz;

  cf_mem_host #(.SETUP_CYC(SETUP), .PULSE_CYC(PULSE), .HOLD_CYC(HOLD),
                .RST_CYC(RSTC), .SYNC_STAGES(2)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .req_valid_i(req_valid), .req_write_i(req_write), .req_addr_i(req_addr),
    .req_attr_i(req_attr), .req_size_i(req_size), .req_wdata_i(req_wdata),
    .req_ready_o(req_ready), .rsp_done_o(rsp_done), .rsp_rdata_o(rsp_rdata),
    .init_done_o(init_done), .card_addr_o(card_addr),
    .card_ce1_no(ce1_n), .card_ce2_no(ce2_n), .card_reg_no(reg_n),
    .card_oe_no(oe_n), .card_we_no(we_n), .card_reset_o(card_rst),
    .card_data_io(card_data), .card_ready_i(card_rdy)
  );

  typedef struct {
    logic        write;
    logic        attr;
    logic [1:0]  size;
    logic [10:0] addr;
    logic [15:0] wdata;
  } item_t;

  item_t exp_q[$];
  int checks = 0;
  int errors = 0;
  int accepted = 0;
  int dones = 0;

  task automatic chk(input logic ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // monitor / scoreboard
  logic        in_acc = 1'b0;
  int          n_s, n_p, n_h;
  logic        seen_oe, seen_we;
  logic        f_ce1, f_ce2, f_reg;
  logic [10:0] f_addr;
  logic [15:0] wbus;

  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (rsp_done) dones++;
      if (!(ce1_n && ce2_n)) begin
        if (!in_acc) begin
          in_acc = 1'b1; n_s = 0; n_p = 0; n_h = 0;
          seen_oe = 1'b0; seen_we = 1'b0;
          f_ce1 = ce1_n; f_ce2 = ce2_n; f_reg = reg_n; f_addr = card_addr;
        end
        if (req_ready) chk(1'b0, "R10", "ready during access", 1, 0);
        if (!oe_n || !we_n) begin
          n_p++;
          if (!oe_n) seen_oe = 1'b1;
          if (!we_n) seen_we = 1'b1;
          wbus = card_data;
        end else if (n_p == 0) n_s++;
        else n_h++;
      end else if (in_acc) begin
        item_t it;
        logic e_ce1, e_ce2, e_a0;
        logic [10:0] ba;
        logic [15:0] er;
        in_acc = 1'b0;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R10", "access with no request", 0, 1);
        end else begin
          it = exp_q.pop_front();
          case (it.size)
            2'b00:   begin e_ce1 = 0; e_ce2 = 1; e_a0 = it.addr[0]; end
            2'b10:   begin e_ce1 = 1; e_ce2 = 0; e_a0 = it.addr[0]; end
            default: begin e_ce1 = 0; e_ce2 = 0; e_a0 = 1'b0; end
          endcase
          ba = {it.addr[10:1], e_a0};
          chk(rsp_done == 1'b1, "R10", "done at end of access", rsp_done, 1);
          chk({f_ce1, f_ce2} == {e_ce1, e_ce2},
              it.size == 2'b00 ? "R4" : (it.size == 2'b10 ? "R5" : "R3"),
              "enable pattern", {f_ce1, f_ce2}, {e_ce1, e_ce2});
          chk(f_addr == ba, "R3", "card address", f_addr, ba);
          chk(f_reg == !it.attr, "R6", "space select", f_reg, !it.attr);
          chk({n_s, n_p, n_h} == {SETUP, PULSE, HOLD}, "R9", "phase lengths",
              (n_s << 16) | (n_p << 8) | n_h, (SETUP << 16) | (PULSE << 8) | HOLD);
          if (it.write) begin
            chk(seen_we && !seen_oe, "R8", "write strobe only", {seen_oe, seen_we}, 2'b01);
            case (it.size)
              2'b00:   chk(wbus[7:0] == it.wdata[7:0], "R4", "byte write lane", wbus[7:0], it.wdata[7:0]);
              2'b10:   chk(wbus[15:8] == it.wdata[7:0], "R5", "odd write lane", wbus[15:8], it.wdata[7:0]);
              default: chk(wbus == it.wdata, "R8", "word write bus", wbus, it.wdata);
            endcase
          end else begin
            chk(seen_oe && !seen_we, "R7", "read strobe only", {seen_oe, seen_we}, 2'b10);
            case (it.size)
              2'b00:   er = {8'h00, pat(ba)[7:0]};
              2'b10:   er = {8'h00, pat(ba)[15:8]};
              default: er = pat(ba);
            endcase
            chk(rsp_rdata == er, "R7", "read data", rsp_rdata, er);
          end
        end
      end
    end
  end

  task automatic send(input logic w, input logic at, input logic [1:0] sz,
                      input logic [10:0] a, input logic [15:0] d);
    item_t it;
    @(negedge clk_i);
    while (!req_ready) @(negedge clk_i);
    it.write = w; it.attr = at; it.size = sz; it.addr = a; it.wdata = d;
    exp_q.push_back(it);
    req_valid = 1'b1; req_write = w; req_attr = at; req_size = sz;
    req_addr = a; req_wdata = d;
    @(posedge clk_i);
    #1 req_valid = 1'b0;
    accepted++;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int rc;
    rst_ni = 1'b0; card_rdy = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    req_attr = 1'b0; req_size = 2'b00; req_addr = '0; req_wdata = '0;
    repeat (4) @(negedge clk_i);
    chk(card_rst == 1'b1, "R1", "card reset in reset", card_rst, 1);
    chk({ce1_n, ce2_n, oe_n, we_n} == 4'hF, "R1", "lines idle in reset",
        {ce1_n, ce2_n, oe_n, we_n}, 4'hF);
    chk(req_ready == 1'b0, "R1", "not ready in reset", req_ready, 0);
    rst_ni = 1'b1;
    #1 rc = card_rst ? 1 : 0;
    @(negedge clk_i);
    while (card_rst) begin
      rc++;
      if (!(ce1_n && ce2_n) || req_ready) chk(1'b0, "R1", "quiet during card reset", 1, 0);
      @(negedge clk_i);
    end
    chk(rc == RSTC, "R1", "card reset length", rc, RSTC);
    repeat (5) @(negedge clk_i);
    chk(init_done == 1'b0, "R2", "init waits for READY", init_done, 0);
    chk(req_ready == 1'b0, "R2", "no accept before init", req_ready, 0);
    card_rdy = 1'b1;
    repeat (6) @(negedge clk_i);
    chk(init_done == 1'b1, "R2", "init after READY", init_done, 1);

    send(1'b0, 1'b0, 2'b01, 11'h123, 16'h0);     // R3 word read, odd addr
    send(1'b0, 1'b1, 2'b00, 11'h201, 16'h0);     // R4 byte read attr, odd
    send(1'b0, 1'b1, 2'b00, 11'h200, 16'h0);     // R4 even
    send(1'b0, 1'b0, 2'b10, 11'h055, 16'h0);     // R5
    send(1'b1, 1'b0, 2'b01, 11'h3FE, 16'hA5C3);  // R8 word write
    send(1'b1, 1'b1, 2'b00, 11'h0F1, 16'h117E);  // R4 byte write
    send(1'b1, 1'b0, 2'b10, 11'h010, 16'h2299);  // R5 odd write
    send(1'b0, 1'b1, 2'b11, 11'h7FF, 16'h0);     // R3 size 11 as word
    for (int i = 0; i < 12; i++)
      send(i[0], i[1], 2'(i % 3), 11'(i * 173 + 5), 16'(i * 4099));

    while (in_acc || exp_q.size() != 0) @(negedge clk_i);
    // R11: request waiting on busy card
    card_rdy = 1'b0;
    repeat (4) @(negedge clk_i);
    begin
      item_t it;
      it.write = 1'b0; it.attr = 1'b0; it.size = 2'b00; it.addr = 11'h2AA; it.wdata = '0;
      exp_q.push_back(it);
    end
    req_valid = 1'b1; req_write = 1'b0; req_attr = 1'b0; req_size = 2'b00; req_addr = 11'h2AA;
    repeat (6) @(negedge clk_i);
    chk(ce1_n && ce2_n, "R11", "no enable while busy", {ce1_n, ce2_n}, 2'b11);
    chk(exp_q.size() == 1, "R11", "request still pending", exp_q.size(), 1);
    card_rdy = 1'b1;
    while (ce1_n && ce2_n) @(negedge clk_i);
    req_valid = 1'b0;
    accepted++;
    while (in_acc || exp_q.size() != 0) @(negedge clk_i);
    repeat (3) @(negedge clk_i);
    chk(dones == accepted, "R10", "done count", dones, accepted);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule